// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block turns one fast source clock into four banks of divided clocks. Bank A has one line, bank B one line, bank C two lines and bank D five lines. Each bank picks its own division ratio. Every output is a registered tap of one shared free-running 3-bit counter, so all banks stay phase-aligned. Their rising edges meet at each counter wrap.

In normal operation the source is an oscillator clock, taken here as an ordinary input. In bypass test mode the source is one of two reference clocks, picked by a reference select. Moving between oscillator and reference goes through a glitch-free handshake with two synchronizer stages per side. Because the bypass path has no timing floor, it keeps working with very slow or stopped references.

An active-low output enable gates all banks. Changes to the enable and to the ratio selects are synchronized into the source domain and applied only at a counter wrap. This means no shortened or runt pulse ever reaches an output. Control values expected after power-up are: reference select 0, bypass control 1 (oscillator), output enable 0 (on), and all ratio selects 0.

Top module: `bank_clock_divider`

## Requirements
- R1: Bank A divides the source by 2 when `fselA` is 0 and by 4 when `fselA` is 1.
- R2: Banks B, C and D each divide the source by 4 when their select is 0 and by 8 when it is 1.
- R3: All lines within a bank carry the same waveform at all times.
- R4: In bypass mode, `refSel` = 0 feeds the dividers from `refDiff` and `refSel` = 1 feeds them from `refSe`.
- R5: When `pllEn` is 0, the chosen reference drives the dividers, at any frequency down to a few hundred kHz or lower. When `pllEn` is 1, `oscClk` drives them.
- R6: While `oeN` is 1, every output is held low after the synchronizer delay and the next wrap. While `oeN` is 0, the outputs toggle.
- R7: All enabled outputs rise together at each rising edge of the slowest bank. Bank A always rises when bank D rises.
- R8: After re-enable, outputs resume at a counter wrap. The first high phase has full width, and the other banks rise in the same instant.
- R9: A ratio select change takes effect only at a counter wrap. Every high or low phase on a bank is therefore a valid half-period of either its old or its new ratio.
- R10: Switching between oscillator and reference is glitch-free. The two source gates are never open at once, and no output edge follows another by less than half of the faster clock's period.
- R11: Asynchronous reset `rst` clears the counter and drives every output low. Outputs stay low until the first wrap after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset |
| oscClk | input | 1 | Oscillator clock, the normal divider source |
| refDiff | input | 1 | Reference clock picked when `refSel` is 0 |
| refSe | input | 1 | Reference clock picked when `refSel` is 1 |
| refSel | input | 1 | Reference choice for bypass mode |
| pllEn | input | 1 | 1: oscillator source, 0: bypass to the reference |
| oeN | input | 1 | Active-low output enable |
| fselA | input | 1 | Bank A ratio: 0 gives /2, 1 gives /4 |
| fselB | input | 1 | Bank B ratio: 0 gives /4, 1 gives /8 |
| fselC | input | 1 | Bank C ratio: 0 gives /4, 1 gives /8 |
| fselD | input | 1 | Bank D ratio: 0 gives /4, 1 gives /8 |
| qA | output | 1 | Bank A clock |
| qB | output | 1 | Bank B clock |
| qC | output | 2 | Bank C clocks |
| qD | output | 5 | Bank D clocks |

## Verification
A ratio select or enable change passes two source-clock synchronizer stages and then waits for the next wrap, at most eight source edges later. The bench therefore waits 40 oscillator cycles before it measures periods from consecutive rising edges. A source switch needs two edges of the incoming clock plus a falling edge, after the outgoing gate has closed. In bypass, the bench waits several microseconds (many reference periods) before it measures. Phase widths and edge spacing are checked continuously by edge monitors. Alignment is judged by comparing rise timestamps one nanosecond after the slowest bank's rise.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int CNT_W = 3;

  typedef struct packed {
    logic outEn;
    logic selA;
    logic selB;
    logic selC;
    logic selD;
  } divStrobe_t;
endpackage

// File: rtl/src_switch.sv
`timescale 1ns/1ps
module src_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic rst,
  input  logic oscClk,
  input  logic refDiff,
  input  logic refSe,
  input  logic refSel,
  input  logic pllEn,
  output logic srcClk
);
  logic refClk;
  logic oscReq, refReq;
  logic [SYNC_STAGES-1:0] oscSync, refSync;
  logic oscGate, refGate;

  assign refClk = refSel ? refSe : refDiff;

  // each side may open only after the other side's gate is seen closed
  assign oscReq = pllEn & ~refGate;
  assign refReq = ~pllEn & ~oscGate;

  always_ff @(posedge oscClk or posedge rst) begin
    if (rst) oscSync <= '0;
    else     oscSync <= {oscSync[SYNC_STAGES-2:0], oscReq};
  end

  // gate changes while its clock is low, so no partial high phase passes
  always_ff @(negedge oscClk or posedge rst) begin
    if (rst) oscGate <= 1'b0;
    else     oscGate <= oscSync[SYNC_STAGES-1];
  end

  always_ff @(posedge refClk or posedge rst) begin
    if (rst) refSync <= '0;
    else     refSync <= {refSync[SYNC_STAGES-2:0], refReq};
  end

  always_ff @(negedge refClk or posedge rst) begin
    if (rst) refGate <= 1'b0;
    else     refGate <= refSync[SYNC_STAGES-1];
  end

  assign srcClk = (oscClk & oscGate) | (refClk & refGate);

  // R10: the two source gates never open together
  assert_gates_exclusive_R10: assert property (
    @(posedge oscClk) disable iff (rst) !(oscGate && refGate));
endmodule

// File: rtl/div_ctrl.sv
`timescale 1ns/1ps
module div_ctrl
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       srcClk,
  input  logic       rst,
  input  logic       oeN,
  input  logic       fselA,
  input  logic       fselB,
  input  logic       fselC,
  input  logic       fselD,
  input  logic       wrap,
  output divStrobe_t strobe
);
  localparam int CTRL_W = 5;

  logic [SYNC_STAGES-1:0][CTRL_W-1:0] ctrlPipe;
  logic [CTRL_W-1:0] ctrlSync;
  divStrobe_t held, fresh;

  always_ff @(posedge srcClk or posedge rst) begin
    if (rst) ctrlPipe <= '0;
    else     ctrlPipe <= {ctrlPipe[SYNC_STAGES-2:0], {oeN, fselA, fselB, fselC, fselD}};
  end

  assign ctrlSync = ctrlPipe[SYNC_STAGES-1];

  always_comb begin
    fresh.outEn = ~ctrlSync[4];
    fresh.selA  = ctrlSync[3];
    fresh.selB  = ctrlSync[2];
    fresh.selC  = ctrlSync[1];
    fresh.selD  = ctrlSync[0];
  end

  // settings are taken only on the edge that wraps the counter
  always_ff @(posedge srcClk or posedge rst) begin
    if (rst)       held <= '0;
    else if (wrap) held <= fresh;
  end

  assign strobe = wrap ? fresh : held;

  // R9: applied settings stay put between wraps
  assert_sel_at_wrap_R9: assert property (
    @(posedge srcClk) disable iff (rst) !wrap |=> $stable(held));
endmodule

// File: rtl/div_datapath.sv
`timescale 1ns/1ps
module div_datapath
  import clkdiv_pkg::*;
#(
  parameter int C_LINES = 2,
  parameter int D_LINES = 5
) (
  input  logic               srcClk,
  input  logic               rst,
  input  divStrobe_t         strobe,
  output logic               wrap,
  output logic               qA,
  output logic               qB,
  output logic [C_LINES-1:0] qC,
  output logic [D_LINES-1:0] qD
);
  logic [CNT_W-1:0] cnt, cntNext;
  logic tapA, tapB, tapC, tapD;

  assign cntNext = cnt + 1'b1;
  assign wrap    = &cnt;

  always_ff @(posedge srcClk or posedge rst) begin
    if (rst) cnt <= '0;
    else     cnt <= cntNext;
  end

  // inverted counter bits rise together when the counter returns to zero
  assign tapA = strobe.outEn & ~cntNext[strobe.selA ? 1 : 0];
  assign tapB = strobe.outEn & ~cntNext[strobe.selB ? 2 : 1];
  assign tapC = strobe.outEn & ~cntNext[strobe.selC ? 2 : 1];
  assign tapD = strobe.outEn & ~cntNext[strobe.selD ? 2 : 1];

  always_ff @(posedge srcClk or posedge rst) begin
    if (rst) begin
      qA <= 1'b0;
      qB <= 1'b0;
    end else begin
      qA <= tapA;
      qB <= tapB;
    end
  end

  // one flop per line so each line drives its own load
  for (genvar gc = 0; gc < C_LINES; gc++) begin : gLineC
    always_ff @(posedge srcClk or posedge rst) begin
      if (rst) qC[gc] <= 1'b0;
      else     qC[gc] <= tapC;
    end
  end

  for (genvar gd = 0; gd < D_LINES; gd++) begin : gLineD
    always_ff @(posedge srcClk or posedge rst) begin
      if (rst) qD[gd] <= 1'b0;
      else     qD[gd] <= tapD;
    end
  end

  // R3: lines of a bank match
  assert_lines_match_R3: assert property (
    @(posedge srcClk) disable iff (rst)
      (qC == {C_LINES{qC[0]}}) && (qD == {D_LINES{qD[0]}}));

  // R7: bank A rises whenever bank D rises
  assert_aligned_rise_R7: assert property (
    @(posedge srcClk) disable iff (rst) $rose(qD[0]) |-> $rose(qA));

  // R6: a disabled cycle leaves every output low
  assert_disabled_low_R6: assert property (
    @(posedge srcClk) disable iff (rst)
      !strobe.outEn |=> (!qA && !qB && qC == '0 && qD == '0));

  // R11: outputs stay low until the counter first wraps after reset
  assert_low_before_wrap_R11: assert property (
    @(posedge srcClk) disable iff (rst)
      (cnt == '0 && !qA && !qB) |-> (qC == '0 && qD == '0));
endmodule

// File: rtl/bank_clock_divider.sv
`timescale 1ns/1ps
module bank_clock_divider
  import clkdiv_pkg::*;
#(
  parameter int C_LINES     = 2,
  parameter int D_LINES     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               rst,
  input  logic               oscClk,
  input  logic               refDiff,
  input  logic               refSe,
  input  logic               refSel,
  input  logic               pllEn,
  input  logic               oeN,
  input  logic               fselA,
  input  logic               fselB,
  input  logic               fselC,
  input  logic               fselD,
  output logic               qA,
  output logic               qB,
  output logic [C_LINES-1:0] qC,
  output logic [D_LINES-1:0] qD
);
  logic       srcClk;
  logic       wrap;
  divStrobe_t strobe;

  src_switch #(.SYNC_STAGES(SYNC_STAGES)) uSrc (
    .rst(rst), .oscClk(oscClk), .refDiff(refDiff), .refSe(refSe),
    .refSel(refSel), .pllEn(pllEn), .srcClk(srcClk));

  div_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .srcClk(srcClk), .rst(rst), .oeN(oeN), .fselA(fselA), .fselB(fselB),
    .fselC(fselC), .fselD(fselD), .wrap(wrap), .strobe(strobe));

  div_datapath #(.C_LINES(C_LINES), .D_LINES(D_LINES)) uPath (
    .srcClk(srcClk), .rst(rst), .strobe(strobe), .wrap(wrap),
    .qA(qA), .qB(qB), .qC(qC), .qD(qD));
endmodule

// File: tb/sim_bank_clock_divider.sv
`timescale 1ns/1ps
module sim_bank_clock_divider;
  logic rst = 1'b1, oscClk = 1'b0, refDiff = 1'b0, refSe = 1'b0;
  logic refSel = 1'b0, pllEn = 1'b1, oeN = 1'b0;
  logic fselA = 1'b0, fselB = 1'b0, fselC = 1'b0, fselD = 1'b0;
  logic qA, qB;
  logic [1:0] qC;
  logic [4:0] qD;

  realtime seHalf = 25.0;
  int checks = 0, failures = 0, runtCount = 0;
  bit widthMon = 1'b0;
  realtime prevA = -1.0, prevB = -1.0, lastEdgeA = -1.0, lastEdgeB = -1.0;
  realtime riseA = 0.0, riseB = 0.0, riseC = 0.0;

  bank_clock_divider u0 (
    .rst(rst), .oscClk(oscClk), .refDiff(refDiff), .refSe(refSe),
    .refSel(refSel), .pllEn(pllEn), .oeN(oeN), .fselA(fselA), .fselB(fselB),
    .fselC(fselC), .fselD(fselD), .qA(qA), .qB(qB), .qC(qC), .qD(qD));

  always #10 oscClk = ~oscClk;      // 50 MHz
  always #15 refDiff = ~refDiff;
  always begin #(seHalf) refSe = ~refSe; end

  function automatic bit near(realtime a, realtime b);
    return (a - b < 0.5) && (b - a < 0.5);
  endfunction

  function automatic int ratioA(logic s); return s ? 4 : 2; endfunction
  function automatic int ratioO(logic s); return s ? 8 : 4; endfunction

  task automatic check(bit ok, string req, string what, realtime act, realtime exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  always @(posedge qA) riseA = $realtime;
  always @(posedge qB) riseB = $realtime;
  always @(posedge qC[0]) riseC = $realtime;

  // edge spacing and phase widths of banks A and B
  always @(qA) if (!rst) begin
    if (lastEdgeA > 0.0 && $realtime - lastEdgeA < 10.0) runtCount++;
    lastEdgeA = $realtime;
    if (widthMon && prevA > 0.0)
      check(near($realtime - prevA, 20.0) || near($realtime - prevA, 40.0),
            "R9", "bank A phase width", $realtime - prevA, 20.0);
    prevA = widthMon ? $realtime : -1.0;
  end

  always @(qB) if (!rst) begin
    if (lastEdgeB > 0.0 && $realtime - lastEdgeB < 10.0) runtCount++;
    lastEdgeB = $realtime;
    if (widthMon && prevB > 0.0)
      check(near($realtime - prevB, 40.0) || near($realtime - prevB, 80.0),
            "R9", "bank B phase width", $realtime - prevB, 40.0);
    prevB = widthMon ? $realtime : -1.0;
  end

  task automatic periodOf(input int which, output realtime p);
    realtime t1;
    case (which)
      0: begin @(posedge qA); t1 = $realtime; @(posedge qA); end
      1: begin @(posedge qB); t1 = $realtime; @(posedge qB); end
      2: begin @(posedge qC[0]); t1 = $realtime; @(posedge qC[0]); end
      default: begin @(posedge qD[0]); t1 = $realtime; @(posedge qD[0]); end
    endcase
    p = $realtime - t1;
  endtask

  task automatic checkAllPeriods(realtime srcPer);
    realtime p;
    periodOf(0, p); check(near(p, srcPer * ratioA(fselA)), "R1", "bank A period", p, srcPer * ratioA(fselA));
    periodOf(1, p); check(near(p, srcPer * ratioO(fselB)), "R2", "bank B period", p, srcPer * ratioO(fselB));
    periodOf(2, p); check(near(p, srcPer * ratioO(fselC)), "R2", "bank C period", p, srcPer * ratioO(fselC));
    periodOf(3, p); check(near(p, srcPer * ratioO(fselD)), "R2", "bank D period", p, srcPer * ratioO(fselD));
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    finishRun();
  end

  initial begin
    realtime p, t;
    void'($urandom(32'd1234));

    // R11: outputs low in reset and until the first wrap
    #50;
    check(qA == 0 && qB == 0 && qC == 0 && qD == 0, "R11", "outputs in reset", real'({qA, qB, qC, qD}), 0.0);
    #50 rst = 1'b0;
    repeat (3) @(posedge oscClk);
    @(negedge oscClk);
    check(qA == 0 && qB == 0 && qC == 0 && qD == 0, "R11", "outputs before first wrap", real'({qA, qB, qC, qD}), 0.0);

    // default settings, oscillator source
    repeat (40) @(posedge oscClk);
    checkAllPeriods(20.0);
    widthMon = 1'b1;

    // random ratio mixes
    for (int it = 0; it < 8; it++) begin
      {fselA, fselB, fselC, fselD} = 4'($urandom_range(0, 15));
      repeat (40) @(posedge oscClk);
      checkAllPeriods(20.0);
      for (int s = 0; s < 8; s++) begin
        @(negedge oscClk);
        check(qC == {2{qC[0]}} && qD == {5{qD[0]}}, "R3", "bank lines identical", real'({qC, qD}), 0.0);
      end
      @(posedge qD[0]); t = $realtime; #1;
      check(near(riseA, t), "R7", "bank A rises with D", riseA, t);
      if (ratioO(fselB) <= ratioO(fselD)) check(near(riseB, t), "R7", "bank B rises with D", riseB, t);
      if (ratioO(fselC) <= ratioO(fselD)) check(near(riseC, t), "R7", "bank C rises with D", riseC, t);
    end

    // R9: select changes at arbitrary moments, width monitor watching
    for (int g = 0; g < 10; g++) begin
      #($urandom_range(1, 79));
      fselA = ~fselA;
      #($urandom_range(1, 79));
      fselB = ~fselB;
    end
    repeat (40) @(posedge oscClk);

    // R6: disable
    widthMon = 1'b0;
    fselA = 1'b0; fselB = 1'b1; fselC = 1'b0; fselD = 1'b1;
    repeat (40) @(posedge oscClk);
    oeN = 1'b1;
    repeat (30) @(posedge oscClk);
    begin
      bit anyHigh = 1'b0;
      for (int s = 0; s < 40; s++) begin
        @(negedge oscClk);
        if (qA || qB || qC != 0 || qD != 0) anyHigh = 1'b1;
      end
      check(!anyHigh, "R6", "outputs while disabled", real'(anyHigh), 0.0);
    end

    // R8: re-enable at a wrap, full first pulse
    @(negedge oscClk);
    oeN = 1'b0;
    @(posedge qA); t = $realtime; #1;
    check(qB == 1'b1 && near(riseB, t), "R8", "bank B resumes with A", riseB, t);
    @(negedge qA);
    check(near($realtime - t, 20.0), "R8", "first high width", $realtime - t, 20.0);
    repeat (40) @(posedge oscClk);
    periodOf(0, p); check(near(p, 40.0), "R6", "bank A toggles after enable", p, 40.0);

    // R4/R5: bypass to the differential reference
    fselB = 1'b0;
    refSel = 1'b0; pllEn = 1'b0;
    #2000;
    periodOf(0, p); check(near(p, 60.0), "R4", "bypass refDiff bank A", p, 60.0);
    periodOf(1, p); check(near(p, 120.0), "R5", "bypass refDiff bank B", p, 120.0);

    // R4: bypass to the single-ended reference
    pllEn = 1'b1; #1000;
    refSel = 1'b1; pllEn = 1'b0;
    #2000;
    periodOf(0, p); check(near(p, 100.0), "R4", "bypass refSe bank A", p, 100.0);

    // R5: very slow reference still passes
    pllEn = 1'b1; #1000;
    seHalf = 500.0; #3000;
    pllEn = 1'b0;
    #20000;
    periodOf(0, p); check(near(p, 2000.0), "R5", "slow reference bank A", p, 2000.0);

    // R5: back to the oscillator
    pllEn = 1'b1;
    #8000;
    periodOf(0, p); check(near(p, 40.0), "R5", "oscillator restored bank A", p, 40.0);

    // R10: no edge closer than half the faster clock period
    check(runtCount == 0, "R10", "short pulses seen", real'(runtCount), 0.0);

    finishRun();
  end
endmodule